// File: doc/BRIEF.md
# Dual-Compare Event Counter Timer

This block is a programmable up-counter with two compare values. Compare value A is the terminal count: after the counter holds A it goes back to zero on the next count, so one period is A+1 counts long. Compare value B places an edge inside that period. A match on B sets a pulse-width output flip-flop and a match on A clears it, so B fixes the phase of the output within the period.

Each count step comes from one of two sources. It can be every system clock cycle, or one rising edge of an external event line. The event line is resynchronised to the system clock, and its edges are detected after that. Software programs the timer through a small write port. It writes the two compare values and a mode word into their registers. It first sets the initialise bit with the run bit clear, which zeroes the counter and the output. It then sets the run bit to start counting. Each compare event also sets its own sticky request flag. The flag drives an interrupt line through a per-flag enable.

Top module: `evtimer_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the counter, the output flip-flop, both flags and all registers return to their reset values. The outputs tmr_out, irq_a and irq_b read 0 from the next cycle on.
- R2: The write port uses these addresses: 0 is compare A, 1 is compare B, 2 is the mode word, and 3 is the flag-clear word. In the mode word, bit 0 is initialise, bit 1 is run, bit 2 selects event counting (0 means system clock), bit 3 enables irq_a and bit 4 enables irq_b.
- R3: While run is 1 in clock mode, the counter advances on every cycle. When a count step is taken with the counter equal to A, the counter goes to 0, so a period lasts A+1 counts.
- R4: A count step taken with the counter equal to B sets tmr_out. A count step taken with the counter equal to A clears tmr_out. If both happen on the same step, the clear wins.
- R5: A value of all ones in compare B never matches, so tmr_out is never set and the B flag is never raised.
- R6: When initialise is 1 and run is 0, the counter and tmr_out are cleared on each edge and no counting occurs. When both bits are 0, everything holds.
- R7: A write that sets run starts counting on the first edge after the mode register takes the new value. It does not count on the edge that performs the write.
- R8: Flag A is set on every compare-A step and flag B on every compare-B step. Both flags are sticky. Writing address 3 with bit 0 (A) or bit 1 (B) at 0 clears that flag, and a 1 in that bit leaves it unchanged. A set on the same edge as a clear wins.
- R9: irq_a equals flag A gated by its enable bit, and irq_b equals flag B gated by its enable bit. A masked flag is still set and appears on its line as soon as the enable bit is written to 1.
- R10: In event mode, evt_in passes through two synchroniser flops and a rising-edge detector. Each rising edge gives exactly one count step, taken on the third clock edge after evt_in rises. The line must stay at least two cycles high and two cycles low.
- R11: Writes to A or B while run is 1 take effect at the next wrap to zero. While run is 0 they take effect one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| evt_in | input | 1 | Asynchronous external event line |
| tmr_out | output | 1 | Set-reset timer output |
| irq_a | output | 1 | Compare-A request, masked by its enable |
| irq_b | output | 1 | Compare-B request, masked by its enable |

## Verification
All outputs come from registers. A count step, a flag change or a flag clear shows up one cycle after the edge that causes it. An event edge needs three edges from evt_in to the count step, plus one more edge before its effect is seen. A compare write made while stopped reaches the active compare one edge after the write. The bench model applies each of these delays to its own state on every rising edge. It compares all three outputs on the falling edge of every cycle after reset, so each result is checked in exactly the cycle it is due.

// File: rtl/evtimer_pkg.sv
// Shared definitions for the event counter timer: register addresses
// and the layout of the mode word. Assumes a two-bit write address.
package evtimer_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CMP_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_FLAG  = 2'd3;

    // Mode word, bit 0 first: load, run, src_evt, ie_a, ie_b.
    typedef struct packed {
        logic ie_b;
        logic ie_a;
        logic src_evt;
        logic run;
        logic load;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/evtimer_edge.sv
// Event input conditioner: a chain of SYNC_STAGES flops brings evt_in into
// the clock domain, and one extra flop detects its rising edge.
// Assumes evt_in stays high and low for at least two cycles each.
module evtimer_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_pulse
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw input through the synchroniser and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], evt_in};
        end
    end

    // One-cycle pulse on a synchronised low-to-high transition.
    always_comb begin
        evt_pulse = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    end

endmodule

// File: rtl/evtimer_regs.sv
// Register file: the written (shadow) compare values, the active compare
// values used by the counter, the mode word and the flag-clear strobes.
// The active values follow the shadows every cycle while stopped and only
// at a wrap while running.
module evtimer_regs
    import evtimer_pkg::*;
#(
    parameter int          W     = 16,
    parameter logic [W-1:0] RST_A = '1,
    parameter logic [W-1:0] RST_B = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              wrap,
    output logic [W-1:0]      a_act,
    output logic [W-1:0]      b_act,
    output mode_t             mode,
    output logic              clr_a,
    output logic              clr_b
);

    logic [W-1:0] sh_a;
    logic [W-1:0] sh_b;

    // Capture software writes into the shadow compares and the mode word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_a <= RST_A;
            sh_b <= RST_B;
            mode <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CMP_A: sh_a <= wr_data;
                ADDR_CMP_B: sh_b <= wr_data;
                ADDR_MODE:  mode <= mode_t'(wr_data[MODE_W-1:0]);
                default:    ;
            endcase
        end
    end

    // Move shadows into the active compares when stopped or at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_act <= RST_A;
            b_act <= RST_B;
        end else if (!mode.run || wrap) begin
            a_act <= sh_a;
            b_act <= sh_b;
        end
    end

    // Decode flag-clear strobes: a zero bit in a flag write clears it.
    always_comb begin
        clr_a = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[0];
        clr_b = wr_en && (wr_addr == ADDR_FLAG) && !wr_data[1];
    end

endmodule

// File: rtl/evtimer_core.sv
// Counter datapath: selects the count source, compares against the active
// A and B values, wraps at A, drives the set-reset output and the sticky
// flags. An all-ones B never matches. Reset of the output beats set.
module evtimer_core
    import evtimer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mode_t        mode,
    input  logic [W-1:0] a_act,
    input  logic [W-1:0] b_act,
    input  logic         evt_pulse,
    input  logic         clr_a,
    input  logic         clr_b,
    output logic [W-1:0] cnt,
    output logic         tick,
    output logic         wrap,
    output logic         tmr_out,
    output logic         flag_a,
    output logic         flag_b
);

    logic hit_a;
    logic hit_b;
    logic step_b;

    // Choose the count step and evaluate both compares.
    always_comb begin
        tick   = mode.run && (mode.src_evt ? evt_pulse : 1'b1);
        hit_a  = (cnt == a_act);
        hit_b  = (b_act != {W{1'b1}}) && (cnt == b_act);
        wrap   = tick && hit_a;
        step_b = tick && hit_b;
    end

    // Advance, wrap, initialise or hold the counter and the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            tmr_out <= 1'b0;
        end else if (mode.run) begin
            if (tick) begin
                cnt <= hit_a ? '0 : cnt + 1'b1;
                if (hit_a) begin
                    tmr_out <= 1'b0;
                end else if (hit_b) begin
                    tmr_out <= 1'b1;
                end
            end
        end else if (mode.load) begin
            cnt     <= '0;
            tmr_out <= 1'b0;
        end
    end

    // Sticky request flags: a compare event sets, a software write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            flag_a <= (flag_a && !clr_a) || wrap;
            flag_b <= (flag_b && !clr_b) || step_b;
        end
    end

endmodule

// File: rtl/evtimer_top.sv
// Top level of the dual-compare event counter timer. Connects the
// register file, the event conditioner and the counter datapath, and
// gates the flags with their enables.
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int          W           = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [W-1:0] RST_A      = '1,
    parameter logic [W-1:0] RST_B      = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              evt_in,
    output logic              tmr_out,
    output logic              irq_a,
    output logic              irq_b
);

    logic [W-1:0] a_act;
    logic [W-1:0] b_act;
    logic [W-1:0] cnt;
    mode_t        mode;
    logic         clr_a;
    logic         clr_b;
    logic         evt_pulse;
    logic         tick;
    logic         wrap;
    logic         flag_a;
    logic         flag_b;

    evtimer_regs #(.W(W), .RST_A(RST_A), .RST_B(RST_B)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wrap    (wrap),
        .a_act   (a_act),
        .b_act   (b_act),
        .mode    (mode),
        .clr_a   (clr_a),
        .clr_b   (clr_b)
    );

    evtimer_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .evt_pulse (evt_pulse)
    );

    evtimer_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .a_act     (a_act),
        .b_act     (b_act),
        .evt_pulse (evt_pulse),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .cnt       (cnt),
        .tick      (tick),
        .wrap      (wrap),
        .tmr_out   (tmr_out),
        .flag_a    (flag_a),
        .flag_b    (flag_b)
    );

    // Gate each sticky flag with its enable bit.
    always_comb begin
        irq_a = flag_a && mode.ie_a;
        irq_b = flag_b && mode.ie_b;
    end

endmodule

// File: rtl/evtimer_chk.sv
// Property checker for evtimer_top, attached by bind. Observes the
// counter, the active compares and the control strobes over time.
module evtimer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic [W-1:0] a_act,
    input logic         tick,
    input logic         wrap,
    input logic         run,
    input logic         load,
    input logic         tmr_out,
    input logic         flag_a,
    input logic         clr_a,
    input logic         evt_pulse
);

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

    p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (cnt == $past(cnt) + 1'b1));

    p_wrap_clears_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !tmr_out);

    p_init_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !run) |=> (cnt == '0 && !tmr_out));

    p_stopped_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !clr_a) |=> flag_a);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);

    p_compare_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> $stable(a_act));

endmodule

bind evtimer_top evtimer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .a_act     (a_act),
    .tick      (tick),
    .wrap      (wrap),
    .run       (mode.run),
    .load      (mode.load),
    .tmr_out   (tmr_out),
    .flag_a    (flag_a),
    .clr_a     (clr_a),
    .evt_pulse (evt_pulse)
);

// File: tb/test_evtimer_top.sv
// Bench for evtimer_top: a behavioural model advanced on every rising
// edge, compared with the outputs on every falling edge.
module test_evtimer_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        evt_in = 1'b0;
    logic        tmr_out;
    logic        irq_a;
    logic        irq_b;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    started = 1'b0;
    string cur_req = "R1";

    // Model state.
    int m_sha, m_shb, m_a, m_b, m_cnt;
    bit m_load, m_run, m_src, m_iea, m_ieb;
    bit m_out, m_fa, m_fb;
    bit m_s1, m_s2, m_s3;

    always #10 clk = ~clk;

    evtimer_top i_evtimer_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt_in  (evt_in),
        .tmr_out (tmr_out),
        .irq_a   (irq_a),
        .irq_b   (irq_b)
    );

    task automatic check(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     cur_req, what, act, exp, cycles);
        end
    endtask

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        bit pulse, tick, hit_a, hit_b, wrap;
        int old_sha, old_shb;
        cycles++;
        started = 1'b1;
        if (!rst_n) begin
            m_sha = 16'hFFFF; m_shb = 16'hFFFF; m_a = 16'hFFFF; m_b = 16'hFFFF;
            m_cnt = 0; m_load = 0; m_run = 0; m_src = 0; m_iea = 0; m_ieb = 0;
            m_out = 0; m_fa = 0; m_fb = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            pulse = m_s2 && !m_s3;
            tick  = m_run && (m_src ? pulse : 1'b1);
            hit_a = (m_cnt == m_a);
            hit_b = (m_b != 16'hFFFF) && (m_cnt == m_b);
            wrap  = tick && hit_a;
            old_sha = m_sha; old_shb = m_shb;
            if (m_fa && wr_en && wr_addr == 2'd3 && !wr_data[0]) m_fa = 0;
            if (m_fb && wr_en && wr_addr == 2'd3 && !wr_data[1]) m_fb = 0;
            if (wrap) m_fa = 1;
            if (tick && hit_b) m_fb = 1;
            if (m_run) begin
                if (tick) begin
                    if (hit_a) begin m_cnt = 0; m_out = 0; end
                    else begin m_cnt = m_cnt + 1; if (hit_b) m_out = 1; end
                end
            end else if (m_load) begin
                m_cnt = 0; m_out = 0;
            end
            if (!m_run || wrap) begin m_a = old_sha; m_b = old_shb; end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_sha = wr_data;
                    2'd1: m_shb = wr_data;
                    2'd2: begin
                        m_load = wr_data[0]; m_run = wr_data[1]; m_src = wr_data[2];
                        m_iea = wr_data[3]; m_ieb = wr_data[4];
                    end
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
        end
    end

    // Compare every output once per cycle, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            check("tmr_out", tmr_out, m_out);
            check("irq_a", irq_a, m_fa && m_iea);
            check("irq_b", irq_b, m_fb && m_ieb);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state.
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R6: initialise with run clear; R11 compare writes while stopped; R2 map.
        cur_req = "R6";
        wr(2'd0, 16'd4);
        wr(2'd1, 16'd1);
        wr(2'd2, 16'h0001);
        idle(3);
        wr(2'd2, 16'h0000);
        idle(3);
        // R7 and R3/R4: start in clock mode with both enables.
        cur_req = "R7";
        wr(2'd2, 16'h001B);
        cur_req = "R3";
        idle(20);
        // R8: clear flag A, keep B; then clear both.
        cur_req = "R8";
        wr(2'd3, 16'h0002);
        idle(3);
        wr(2'd3, 16'h0000);
        idle(6);
        // R9: masked interrupts keep their flags.
        cur_req = "R9";
        wr(2'd2, 16'h0003);
        idle(12);
        wr(2'd2, 16'h001B);
        idle(4);
        // R11: compare writes while running apply at wrap.
        cur_req = "R11";
        wr(2'd0, 16'd2);
        idle(15);
        wr(2'd0, 16'd6);
        wr(2'd1, 16'd3);
        idle(24);
        // R5: all-ones B never matches.
        cur_req = "R5";
        wr(2'd1, 16'hFFFF);
        idle(25);
        // R4: equal compares, clear beats set.
        cur_req = "R4";
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd3);
        idle(2);
        wr(2'd2, 16'h001B);
        idle(16);
        // R10: event counting at a quarter of the clock.
        cur_req = "R10";
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd0);
        idle(2);
        wr(2'd2, 16'h001F);
        for (int i = 0; i < 12; i++) begin
            evt_in = 1'b1; idle(2);
            evt_in = 1'b0; idle(2);
        end
        // R10: slower events with irregular spacing.
        for (int i = 0; i < 6; i++) begin
            evt_in = 1'b1; idle(3 + i);
            evt_in = 1'b0; idle(2 + i);
        end
        // R6: initialise again while in event mode, then hold.
        cur_req = "R6";
        wr(2'd2, 16'h0005);
        idle(4);
        // R1: reset in the middle of activity.
        cur_req = "R1";
        wr(2'd2, 16'h001B);
        idle(5);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule